// File: doc/BRIEF.md
# Vector Multishift Byte Extraction Unit

This unit builds each byte of a vector result by taking an 8-bit window from a 64-bit data lane. The window can start at any bit of the lane. Each lane holds eight control bytes, and control byte j of a lane sets where the window for result byte j of that lane begins. A window that runs past the top bit of the qword continues from bit 0 of the same qword.

The raw result bytes then go through per-byte write enables. A byte that is not enabled either keeps the old destination byte (merge) or is forced to zero (zeroing). The caller can choose a broadcast mode, in which every lane reads data qword 0. The vector length sets how many lanes are active. Lanes above that length are cleared.

The block captures one operation on each cycle in which `in_valid` is high. It presents the registered result one cycle later.

Top module: `mshift_unit`

## Requirements
- R1: Result byte j of lane i sits at bits [64*i+8*j+7 : 64*i+8*j]. It is built from data qword i (bits [64*i+63 : 64*i]) and from the control byte at the same bit position in `ctl_vec`.
- R2: Only bits [5:0] of a control byte set the start position. Bits [7:6] have no effect on the result.
- R3: Bit k (0..7) of a result byte equals data bit ((ctrl + k) mod 64), where ctrl is the 6-bit start position. Starts from 57 to 63 therefore wrap around to bit 0.
- R4: `vlen` selects the number of active lanes: code 0 gives 2 lanes (128 bits), code 1 gives 4 lanes (256 bits), and code 2 gives 8 lanes (512 bits). Code 3 behaves like code 2.
- R5: When `bcast` is 1, every lane uses data bits [63:0] in place of its own qword.
- R6: The enable for result byte j of lane i is `byte_mask[8*i+j]`. When `mask_en` is 0, every byte is enabled, whatever `byte_mask` holds.
- R7: A disabled byte of an active lane takes the matching `old_dst` byte when `zero_mode` is 0. It becomes 0x00 when `zero_mode` is 1.
- R8: Every byte of a lane at or above the active lane count reads 0, whatever the mask, mode or old value.
- R9: An operation presented with `in_valid` high at a rising edge appears on `result` after that edge. `out_valid` equals `in_valid` delayed by one cycle.
- R10: While `in_valid` is low, `result` holds its previous value.
- R11: A synchronous active-high `rst` clears `result` to zero and `out_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Captures an operation at this edge |
| ctl_vec | input | 512 | Control bytes, eight per lane |
| dat_vec | input | 512 | Data qwords, one per lane |
| old_dst | input | 512 | Previous destination, used for merging |
| byte_mask | input | 64 | Per-byte write enables |
| mask_en | input | 1 | 1 = apply byte_mask, 0 = write all bytes |
| zero_mode | input | 1 | 1 = clear disabled bytes, 0 = merge them |
| bcast | input | 1 | 1 = every lane reads data qword 0 |
| vlen | input | 2 | Vector length code |
| out_valid | output | 1 | Result is valid this cycle |
| result | output | 512 | Registered result vector |

## Verification
The bench builds the unit with its default of eight lanes, so that all three vector lengths and the reserved length code can reach the upper-lane clearing path. With eight lanes, an exhaustive sweep over all 256 control byte values covers every start position, together with both upper control bits, in all 64 byte slots at once. The wrapping starts 57 to 63 are also checked on their own against a single-bit data pattern whose expected byte can be worked out by hand. Random vectors then exercise every combination of mask use, merge or zeroing, and broadcast against an arithmetic reference.

// File: rtl/mshift_pkg.sv
package mshift_pkg;

    localparam int QW_W    = 64;
    localparam int BYTE_W  = 8;
    localparam int BPQ     = QW_W / BYTE_W;
    localparam int OFF_W   = $clog2(QW_W);

    typedef logic [QW_W-1:0]   qword_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [OFF_W-1:0]  off_t;

    typedef enum logic [1:0] {
        VL_128 = 2'd0,
        VL_256 = 2'd1,
        VL_512 = 2'd2,
        VL_RSV = 2'd3
    } vlen_e;

    typedef enum logic [1:0] {
        ACT_WRITE = 2'd0,
        ACT_MERGE = 2'd1,
        ACT_ZERO  = 2'd2
    } byte_act_e;

    typedef struct packed {
        logic  mask_en;
        logic  zero_mode;
        logic  bcast;
        vlen_e vlen;
    } mode_t;

    function automatic logic [3:0] lanes_for(vlen_e v);
        case (v)
            VL_128:  lanes_for = 4'd2;
            VL_256:  lanes_for = 4'd4;
            default: lanes_for = 4'd8;
        endcase
    endfunction

    function automatic off_t start_of(byte_t c);
        start_of = c[OFF_W-1:0];
    endfunction

endpackage

// File: rtl/mshift_window.sv
module mshift_window
    import mshift_pkg::*;
(
    input  qword_t data,
    input  byte_t  ctrl,
    output byte_t  win
);
    logic [2*QW_W-1:0] dbl;
    logic [2*QW_W-1:0] shifted;
    off_t              off;

    always_comb begin
        off     = start_of(ctrl);
        dbl     = {data, data};
        shifted = dbl >> off;
        win     = shifted[BYTE_W-1:0];
    end
endmodule

// File: rtl/mshift_byte_gate.sv
module mshift_byte_gate
    import mshift_pkg::*;
(
    input  byte_t raw,
    input  byte_t old,
    input  logic  en,
    input  logic  zero_mode,
    input  logic  lane_on,
    output byte_t q
);
    byte_act_e act;

    always_comb begin
        if (!lane_on)       act = ACT_ZERO;
        else if (en)        act = ACT_WRITE;
        else if (zero_mode) act = ACT_ZERO;
        else                act = ACT_MERGE;

        case (act)
            ACT_WRITE: q = raw;
            ACT_MERGE: q = old;
            default:   q = '0;
        endcase
    end
endmodule

// File: rtl/mshift_lane.sv
module mshift_lane
    import mshift_pkg::*;
(
    input  qword_t           ctl,
    input  qword_t           dat,
    input  qword_t           old,
    input  logic [BPQ-1:0]   en,
    input  logic             zero_mode,
    input  logic             lane_on,
    output qword_t           q
);
    for (genvar j = 0; j < BPQ; j++) begin : g_byte
        byte_t raw;

        mshift_window i_win (
            .data (dat),
            .ctrl (ctl[j*BYTE_W +: BYTE_W]),
            .win  (raw)
        );

        mshift_byte_gate i_gate (
            .raw       (raw),
            .old       (old[j*BYTE_W +: BYTE_W]),
            .en        (en[j]),
            .zero_mode (zero_mode),
            .lane_on   (lane_on),
            .q         (q[j*BYTE_W +: BYTE_W])
        );
    end
endmodule

// File: rtl/mshift_unit.sv
module mshift_unit
    import mshift_pkg::*;
#(
    parameter int MAX_LANES = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic [MAX_LANES*64-1:0]       ctl_vec,
    input  logic [MAX_LANES*64-1:0]       dat_vec,
    input  logic [MAX_LANES*64-1:0]       old_dst,
    input  logic [MAX_LANES*8-1:0]        byte_mask,
    input  logic                          mask_en,
    input  logic                          zero_mode,
    input  logic                          bcast,
    input  logic [1:0]                    vlen,
    output logic                          out_valid,
    output logic [MAX_LANES*64-1:0]       result
);
    localparam int VEC_W  = MAX_LANES * QW_W;
    localparam int MASK_W = MAX_LANES * BPQ;

    mode_t              mode;
    logic [MASK_W-1:0]  eff_en;
    logic [MAX_LANES-1:0] lane_on;
    logic [VEC_W-1:0]   nxt;
    logic [3:0]         n_active;

    always_comb begin
        mode.mask_en   = mask_en;
        mode.zero_mode = zero_mode;
        mode.bcast     = bcast;
        mode.vlen      = vlen_e'(vlen);
        n_active       = lanes_for(mode.vlen);
        eff_en         = mode.mask_en ? byte_mask : '1;
    end

    for (genvar i = 0; i < MAX_LANES; i++) begin : g_lane
        qword_t src;

        assign lane_on[i] = (n_active > 4'(i));
        assign src        = mode.bcast ? dat_vec[QW_W-1:0] : dat_vec[i*QW_W +: QW_W];

        mshift_lane i_lane (
            .ctl       (ctl_vec[i*QW_W +: QW_W]),
            .dat       (src),
            .old       (old_dst[i*QW_W +: QW_W]),
            .en        (eff_en[i*BPQ +: BPQ]),
            .zero_mode (mode.zero_mode),
            .lane_on   (lane_on[i]),
            .q         (nxt[i*QW_W +: QW_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result    <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= nxt;
        end
    end

    // R9: out_valid follows in_valid by one cycle
    a_r9_valid_on: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r9_valid_off: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R10: idle cycles leave the result untouched
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    // R7: zeroing with an empty mask clears every byte
    a_r7_zero_all: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mask_en && zero_mode && byte_mask == '0) |=> (result == '0));

    // R7: merging with an empty mask over the full width returns the old vector
    a_r7_merge_keeps: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mask_en && !zero_mode && byte_mask == '0 &&
         lanes_for(vlen_e'(vlen)) >= 4'(MAX_LANES)) |=> (result == $past(old_dst)));

    // R8: a short vector clears everything above its lanes
    if (MAX_LANES > 2) begin : g_upper_chk
        a_r8_upper_clear: assert property (@(posedge clk) disable iff (rst)
            (in_valid && vlen == 2'd0) |=> (result[VEC_W-1:2*QW_W] == '0));
    end
endmodule

// File: tb/test_mshift_unit.sv
module test_mshift_unit;
    localparam int L = 8;
    localparam int W = L * 64;

    logic           clk = 0;
    logic           rst = 1;
    logic           in_valid = 0;
    logic [W-1:0]   ctl_vec = '0, dat_vec = '0, old_dst = '0;
    logic [L*8-1:0] byte_mask = '0;
    logic           mask_en = 0, zero_mode = 0, bcast = 0;
    logic [1:0]     vlen = 2'd2;
    logic           out_valid;
    logic [W-1:0]   result;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    mshift_unit #(.MAX_LANES(L)) i_mshift_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .ctl_vec(ctl_vec), .dat_vec(dat_vec), .old_dst(old_dst),
        .byte_mask(byte_mask), .mask_en(mask_en), .zero_mode(zero_mode),
        .bcast(bcast), .vlen(vlen), .out_valid(out_valid), .result(result)
    );

    function automatic logic [W-1:0] rnd_vec();
        logic [W-1:0] v;
        for (int i = 0; i < W / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [W-1:0] model(
        logic [W-1:0] c, logic [W-1:0] d, logic [W-1:0] o, logic [L*8-1:0] m,
        logic me, logic zm, logic bc, logic [1:0] vl);
        logic [W-1:0] r;
        int act;
        act = (vl == 2'd0) ? 2 : (vl == 2'd1) ? 4 : 8;
        r = '0;
        for (int i = 0; i < L; i++) begin
            for (int j = 0; j < 8; j++) begin
                int st;
                logic [7:0] b;
                st = c[i*64 + j*8 +: 8] % 64;
                for (int k = 0; k < 8; k++)
                    b[k] = bc ? d[(st + k) % 64] : d[i*64 + (st + k) % 64];
                if (i >= act)                 b = 8'h00;
                else if (me && !m[i*8 + j])   b = zm ? 8'h00 : o[i*64 + j*8 +: 8];
                r[i*64 + j*8 +: 8] = b;
            end
        end
        return r;
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic check_bit(string req, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%b exp=%b", req, act, exp);
        end
    endtask

    task automatic run_op(string req);
        logic [W-1:0] exp;
        exp = model(ctl_vec, dat_vec, old_dst, byte_mask, mask_en, zero_mode, bcast, vlen);
        in_valid = 1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 0;
        check(req, result, exp);
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog act=hung exp=finished");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 result", result, '0);
        check_bit("R11 out_valid", out_valid, 1'b0);
        rst = 0;
        @(negedge clk);

        // R1 R2 R3: every control byte value in every byte slot
        dat_vec = rnd_vec();
        for (int v = 0; v < 256; v++) begin
            for (int b = 0; b < L * 8; b++) ctl_vec[b*8 +: 8] = 8'(v + b);
            run_op("R1/R2/R3 sweep");
        end

        // R2: upper control bits have no effect
        for (int s = 0; s < 64; s++) begin
            logic [W-1:0] a;
            for (int b = 0; b < L * 8; b++) ctl_vec[b*8 +: 8] = 8'(s);
            run_op("R2 low");
            a = result;
            for (int b = 0; b < L * 8; b++) ctl_vec[b*8 +: 8] = 8'(s) | 8'hC0;
            run_op("R2 high");
            check("R2 same", result, a);
        end

        // R3: wrapping starts with only bit 0 set in the data
        dat_vec = '0;
        for (int i = 0; i < L; i++) dat_vec[i*64] = 1'b1;
        for (int s = 57; s < 64; s++) begin
            logic [W-1:0] e;
            for (int b = 0; b < L * 8; b++) begin
                ctl_vec[b*8 +: 8] = 8'(s);
                e[b*8 +: 8] = 8'(1 << (64 - s));
            end
            run_op("R3 wrap");
            check("R3 wrap byte", result, e);
        end

        // R4 R8: all length codes with stale data in the old vector
        for (int r = 0; r < 8; r++) begin
            ctl_vec = rnd_vec(); dat_vec = rnd_vec(); old_dst = rnd_vec();
            byte_mask = rnd_vec()[L*8-1:0];
            vlen = 2'(r);
            mask_en = r[2];
            zero_mode = r[0];
            run_op("R4/R8 length");
        end
        vlen = 2'd2;

        // R5: broadcast
        mask_en = 0;
        for (int r = 0; r < 8; r++) begin
            ctl_vec = rnd_vec(); dat_vec = rnd_vec();
            bcast = 1;
            run_op("R5 bcast");
        end
        bcast = 0;

        // R6 R7: mask use, merge and zero
        for (int r = 0; r < 40; r++) begin
            ctl_vec = rnd_vec(); dat_vec = rnd_vec(); old_dst = rnd_vec();
            byte_mask = rnd_vec()[L*8-1:0];
            mask_en = (r % 4) != 0;
            zero_mode = r[0];
            run_op(mask_en ? "R7 masked" : "R6 mask off");
        end

        // R9 R10: out_valid timing and hold while idle
        begin
            logic [W-1:0] kept;
            mask_en = 0;
            run_op("R9 op");
            kept = result;
            check_bit("R9 out_valid high", out_valid, 1'b1);
            ctl_vec = rnd_vec(); dat_vec = rnd_vec();
            @(negedge clk);
            check_bit("R9 out_valid low", out_valid, 1'b0);
            repeat (3) @(negedge clk);
            check("R10 hold", result, kept);
        end

        // random mix of all modes
        for (int r = 0; r < 300; r++) begin
            ctl_vec = rnd_vec(); dat_vec = rnd_vec(); old_dst = rnd_vec();
            byte_mask = rnd_vec()[L*8-1:0];
            mask_en = $urandom_range(0, 1);
            zero_mode = $urandom_range(0, 1);
            bcast = $urandom_range(0, 1);
            vlen = 2'($urandom_range(0, 3));
            run_op("R1/R4/R5/R6/R7/R8 random");
        end

        done = 1;
        report();
    end
endmodule